// File: doc/BRIEF.md
# Backup RAM Window Controller

This block decodes a battery-backed RAM window on a 24-bit, byte-addressed, big-endian CPU bus. The window overlays cartridge ROM. A two-bit control register enables window reads and write-protects the RAM. The RAM sits outside the block as two byte banks. The even bank holds the bytes at even addresses, which are the high bytes of a word. The odd bank holds the bytes at odd addresses. Both banks read combinationally, so every byte or word access completes in the cycle it is presented.

The window bounds are taken from configuration inputs at reset. Until the device type is known, the block watches the first accesses. A write to the lowest pair of addresses at 0x200000 marks the cartridge as carrying a serial EEPROM. The window then shrinks to that pair, and later accesses go to a stub port where a separate protocol engine can attach. A read higher in the window, made while reads are enabled, marks the device as plain RAM instead. A sticky flag records that the RAM contents changed, so save logic knows when to store them. The save logic clears the flag once it has done so.

Top module: `bram_window_ctrl`

## Requirements
- R1: A byte write to address 0xA130F1 that is outside the window loads control bit 0 (read enable) and bit 1 (write protect) from wdata bits 1:0. All other written bits are ignored. The write leaves the EEPROM mode and the changed flag untouched.
- R2: With read enable set and EEPROM mode off, a read inside the window asserts win_rd_o. A byte read returns the addressed byte in rdata bits 7:0 with bits 15:8 zero. With read enable clear, win_rd_o stays low, so the read falls through to ROM.
- R3: With write protect set, no RAM bank write enable is raised, and the stored bytes keep their values.
- R4: The changed flag is set by a RAM write that alters at least one stored byte. It stays set until cleared. A write of identical data does not set it.
- R5: A word access uses the even address. A word read returns the even-address byte in bits 15:8 and the odd-address byte in bits 7:0. A word write stores bits 15:8 to the even byte and bits 7:0 to the odd byte. A byte write stores bits 7:0.
- R6: While undetected, any write in the window marks the device detected. A write to 0x200000 or 0x200001 additionally turns EEPROM mode on from the next access, and shrinks the window to those two bytes. In EEPROM mode, window accesses go to the stub port and never to the RAM. Reads in the window return eep_rdata_i in bits 7:0 whatever the read-enable bit is.
- R7: While undetected, a read with read enable set, inside the window and above 0x200001, marks plain RAM. A later write to 0x200000 then stays a RAM write, and EEPROM mode stays off.
- R8: Reset clears the control bits, the detection state, EEPROM mode and the changed flag, and loads the window bounds from cfg_start_i and cfg_end_i.
- R9: clr_changed_i clears the changed flag at the next edge. If a changing write happens in the same cycle, the flag ends up set.
- R10: An access outside the window raises no RAM write enable and leaves win_rd_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_start_i | input | 24 | Window first byte address (even), loaded at reset |
| cfg_end_i | input | 24 | Window last byte address, loaded at reset |
| cyc_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 write, 0 read |
| word_i | input | 1 | 1 word access, 0 byte access |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data; bytes use bits 7:0 |
| rdata_o | output | 16 | Read data from the window |
| win_rd_o | output | 1 | Read served by the window rather than ROM |
| ram_addr_o | output | AW-1 | Word index into both RAM banks |
| ram_rdata_even_i | input | 8 | Even bank read data |
| ram_rdata_odd_i | input | 8 | Odd bank read data |
| ram_we_even_o | output | 1 | Even bank write enable |
| ram_we_odd_o | output | 1 | Odd bank write enable |
| ram_wdata_even_o | output | 8 | Even bank write data |
| ram_wdata_odd_o | output | 8 | Odd bank write data |
| eep_o | output | 1 | EEPROM mode active |
| eep_req_o | output | 1 | Stub access this cycle |
| eep_we_o | output | 1 | Stub access is a write |
| eep_addr_o | output | 1 | Byte address bit 0 of the stub access |
| eep_wdata_o | output | 8 | Stub write data |
| eep_rdata_i | input | 8 | Stub read data |
| changed_o | output | 1 | Sticky RAM-changed flag |
| clr_changed_i | input | 1 | Clear request for the changed flag |

## Verification
Two things can land on the same clock edge: the clear request from the save logic, and a write that alters a RAM byte. The bench drives clr_changed_i high in the very cycle of a differing byte write. It expects the flag to read 1 after that edge, while a clear with no write drops it to 0. A second collision sits on the first write to 0x200001. That write still reaches the odd RAM bank, and in the same edge it flips the block into EEPROM mode. The bench checks the bank write enable during that cycle. After the edge it checks eep_o and the shrunken window.

// File: rtl/bram_pkg.sv
package bram_pkg;
  typedef struct packed {
    logic wp;
    logic rd_en;
  } ctl_t;

  localparam logic [23:0] CTL_ADDR = 24'hA130F1;
  localparam logic [23:0] EEP_BASE = 24'h200000;
endpackage

// File: rtl/bram_decode.sv
module bram_decode #(
  parameter int AW = 13
) (
  input  logic [23:0]   addr_i,
  input  logic [23:0]   start_i,
  input  logic [23:0]   end_i,
  output logic          in_win_o,
  output logic          ctl_hit_o,
  output logic          above_pair_o,
  output logic [AW-2:0] word_idx_o
);
  import bram_pkg::*;

  logic [23:0] off;

  assign off          = addr_i - start_i;
  assign in_win_o     = (addr_i >= start_i) && (addr_i <= end_i);
  assign ctl_hit_o    = (addr_i == CTL_ADDR);
  assign above_pair_o = (addr_i > (EEP_BASE | 24'h1));
  assign word_idx_o   = off[AW-1:1];
endmodule

// File: rtl/bram_mode.sv
module bram_mode (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [23:0]      cfg_start_i,
  input  logic [23:0]      cfg_end_i,
  input  logic             ctl_wr_i,
  input  logic [1:0]       ctl_data_i,
  input  logic             win_wr_i,
  input  logic             win_rd_i,
  input  logic             above_pair_i,
  input  logic [23:0]      addr_i,
  output bram_pkg::ctl_t   ctl_o,
  output logic             eep_o,
  output logic [23:0]      start_o,
  output logic [23:0]      end_o
);
  import bram_pkg::*;

  ctl_t        ctl_q;
  logic        det_q, eep_q;
  logic [23:0] start_q, end_q;
  logic        pair_hit;

  assign pair_hit = (addr_i[23:1] == EEP_BASE[23:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      det_q   <= 1'b0;
      eep_q   <= 1'b0;
      start_q <= cfg_start_i;
      end_q   <= cfg_end_i;
    end else begin
      if (ctl_wr_i) ctl_q <= ctl_t'(ctl_data_i);
      if (!det_q && win_wr_i) begin
        det_q <= 1'b1;
        if (pair_hit) begin
          eep_q   <= 1'b1;
          start_q <= EEP_BASE;
          end_q   <= EEP_BASE | 24'h1;
        end
      end
      if (!det_q && win_rd_i && ctl_q.rd_en && above_pair_i) det_q <= 1'b1;
    end
  end

  assign ctl_o   = ctl_q;
  assign eep_o   = eep_q;
  assign start_o = start_q;
  assign end_o   = end_q;
endmodule

// File: rtl/bram_dirty.sv
module bram_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bram_window_ctrl.sv
module bram_window_ctrl #(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [23:0]   cfg_start_i,
  input  logic [23:0]   cfg_end_i,
  input  logic          cyc_i,
  input  logic          we_i,
  input  logic          word_i,
  input  logic [23:0]   addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          win_rd_o,
  output logic [AW-2:0] ram_addr_o,
  input  logic [7:0]    ram_rdata_even_i,
  input  logic [7:0]    ram_rdata_odd_i,
  output logic          ram_we_even_o,
  output logic          ram_we_odd_o,
  output logic [7:0]    ram_wdata_even_o,
  output logic [7:0]    ram_wdata_odd_o,
  output logic          eep_o,
  output logic          eep_req_o,
  output logic          eep_we_o,
  output logic          eep_addr_o,
  output logic [7:0]    eep_wdata_o,
  input  logic [7:0]    eep_rdata_i,
  output logic          changed_o,
  input  logic          clr_changed_i
);
  import bram_pkg::*;

  localparam int LANES = 2;

  logic [23:0] eff_addr, win_start, win_end;
  logic        in_win, ctl_hit, above_pair;
  logic        acc_rd, acc_wr, win_rd, win_wr, ctl_wr, ram_wr;
  logic        eep_mode, ctl_wp, ctl_rd_en;
  ctl_t        ctl;

  logic [7:0]       lane_rd [LANES];
  logic [7:0]       lane_wd [LANES];
  logic [LANES-1:0] lane_we, lane_diff;

  assign eff_addr = word_i ? {addr_i[23:1], 1'b0} : addr_i;
  assign acc_rd   = cyc_i & ~we_i;
  assign acc_wr   = cyc_i & we_i;

  bram_decode #(.AW(AW)) u_dec (
    .addr_i      (eff_addr),
    .start_i     (win_start),
    .end_i       (win_end),
    .in_win_o    (in_win),
    .ctl_hit_o   (ctl_hit),
    .above_pair_o(above_pair),
    .word_idx_o  (ram_addr_o)
  );

  assign win_rd = acc_rd & in_win;
  assign win_wr = acc_wr & in_win;
  assign ctl_wr = acc_wr & ~word_i & ctl_hit & ~in_win;

  bram_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_start_i (cfg_start_i),
    .cfg_end_i   (cfg_end_i),
    .ctl_wr_i    (ctl_wr),
    .ctl_data_i  (wdata_i[1:0]),
    .win_wr_i    (win_wr),
    .win_rd_i    (win_rd),
    .above_pair_i(above_pair),
    .addr_i      (eff_addr),
    .ctl_o       (ctl),
    .eep_o       (eep_mode),
    .start_o     (win_start),
    .end_o       (win_end)
  );

  assign ctl_wp    = ctl.wp;
  assign ctl_rd_en = ctl.rd_en;
  // mode switch applies from the next access; the switching write still targets RAM
  assign ram_wr    = win_wr & ~eep_mode & ~ctl_wp;

  assign lane_rd[0] = ram_rdata_even_i;
  assign lane_rd[1] = ram_rdata_odd_i;
  assign lane_wd[0] = word_i ? wdata_i[15:8] : wdata_i[7:0];
  assign lane_wd[1] = wdata_i[7:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l]   = ram_wr & (word_i | (eff_addr[0] == l[0]));
    assign lane_diff[l] = lane_we[l] & (lane_wd[l] != lane_rd[l]);
  end

  assign ram_we_even_o    = lane_we[0];
  assign ram_we_odd_o     = lane_we[1];
  assign ram_wdata_even_o = lane_wd[0];
  assign ram_wdata_odd_o  = lane_wd[1];

  bram_dirty u_dirty (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (|lane_diff),
    .clr_i (clr_changed_i),
    .flag_o(changed_o)
  );

  assign win_rd_o = win_rd & (eep_mode | ctl_rd_en);

  always_comb begin
    rdata_o = '0;
    if (win_rd_o) begin
      if (eep_mode)    rdata_o = {8'h00, eep_rdata_i};
      else if (word_i) rdata_o = {lane_rd[0], lane_rd[1]};
      else             rdata_o = {8'h00, lane_rd[eff_addr[0]]};
    end
  end

  assign eep_o       = eep_mode;
  assign eep_req_o   = cyc_i & in_win & eep_mode;
  assign eep_we_o    = win_wr & eep_mode;
  assign eep_addr_o  = eff_addr[0];
  assign eep_wdata_o = wdata_i[7:0];
endmodule

// File: rtl/bram_window_chk.sv
module bram_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_i,
  input logic        we_i,
  input logic        word_i,
  input logic [23:0] addr_i,
  input logic        clr_changed_i,
  input logic        win_rd_o,
  input logic        eep_o,
  input logic        changed_o,
  input logic        ram_we_even_o,
  input logic        ram_we_odd_o,
  input logic        wp_i,
  input logic        rd_en_i
);
  AST_CTL_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && we_i && !word_i && addr_i == 24'hA130F1) |=> (eep_o == $past(eep_o))); // R1
  AST_RDEN_OFF_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && !we_i && !rd_en_i && !eep_o) |-> !win_rd_o); // R2
  AST_WP_NO_RAM_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !(ram_we_even_o || ram_we_odd_o)); // R3
  AST_CHANGED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (changed_o && !clr_changed_i) |=> changed_o); // R4
  AST_CHANGED_NEEDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!changed_o && !ram_we_even_o && !ram_we_odd_o) |=> !changed_o); // R4
  AST_EEP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eep_o |=> eep_o); // R6
  AST_EEP_NO_RAM_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eep_o |-> !(ram_we_even_o || ram_we_odd_o)); // R6
endmodule

bind bram_window_ctrl bram_window_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_i        (cyc_i),
  .we_i         (we_i),
  .word_i       (word_i),
  .addr_i       (addr_i),
  .clr_changed_i(clr_changed_i),
  .win_rd_o     (win_rd_o),
  .eep_o        (eep_o),
  .changed_o    (changed_o),
  .ram_we_even_o(ram_we_even_o),
  .ram_we_odd_o (ram_we_odd_o),
  .wp_i         (ctl_wp),
  .rd_en_i      (ctl_rd_en)
);

// File: tb/sim_bram_window_ctrl.sv
module sim_bram_window_ctrl;
  localparam int AW    = 6;
  localparam int BYTES = 1 << AW;
  localparam int WORDS = BYTES / 2;
  localparam logic [23:0] BASE = 24'h200000;
  localparam logic [23:0] CTL  = 24'hA130F1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 1'b0, we = 1'b0, word = 1'b0, clr = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  eep_rd = '0;
  logic [15:0] rdata;
  logic        win_rd, we_e, we_o, eep, eep_req, eep_we, eep_a, changed;
  logic [AW-2:0] raddr;
  logic [7:0]  wd_e, wd_o, eep_wd, rd_e, rd_o;

  logic [7:0] mem_e [WORDS];
  logic [7:0] mem_o [WORDS];
  logic [7:0] exp_b [BYTES];

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [15:0] s_rdata;
  logic        s_win, s_we_e, s_we_o, s_eep_we;
  logic [7:0]  s_eep_wd;

  always #5 clk = ~clk;

  bram_window_ctrl #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_start_i(BASE), .cfg_end_i(BASE + 24'(BYTES - 1)),
    .cyc_i(cyc), .we_i(we), .word_i(word), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .win_rd_o(win_rd), .ram_addr_o(raddr),
    .ram_rdata_even_i(rd_e), .ram_rdata_odd_i(rd_o),
    .ram_we_even_o(we_e), .ram_we_odd_o(we_o),
    .ram_wdata_even_o(wd_e), .ram_wdata_odd_o(wd_o),
    .eep_o(eep), .eep_req_o(eep_req), .eep_we_o(eep_we), .eep_addr_o(eep_a),
    .eep_wdata_o(eep_wd), .eep_rdata_i(eep_rd),
    .changed_o(changed), .clr_changed_i(clr)
  );

  assign rd_e = mem_e[raddr];
  assign rd_o = mem_o[raddr];

  always @(posedge clk) begin
    if (we_e) mem_e[raddr] <= wd_e;
    if (we_o) mem_o[raddr] <= wd_o;
  end

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 37 + 11 + k * 90) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample combinational outputs, commit at posedge
  task automatic bus(input logic w, input logic wd, input logic [23:0] a,
                     input logic [15:0] d, input logic c);
    @(negedge clk);
    cyc = 1'b1; we = w; word = wd; addr = a; wdata = d; clr = c;
    #1;
    s_rdata = rdata; s_win = win_rd; s_we_e = we_e; s_we_o = we_o;
    s_eep_we = eep_we; s_eep_wd = eep_wd;
    @(posedge clk); #1;
    cyc = 1'b0; clr = 1'b0;
  endtask

  task automatic idle_clr();
    @(negedge clk); cyc = 1'b0; clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cyc = 1'b0; clr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem_e[i] = 8'h00; mem_o[i] = 8'h00; end
    for (int i = 0; i < BYTES; i++) exp_b[i] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 changed after reset", changed, 0);
    check("R8 eep after reset", eep, 0);
    bus(0, 0, BASE + 24'd4, 16'h0, 0);
    check("R8 read enable clear after reset", s_win, 0);

    bus(1, 0, CTL, 16'h00FD, 0);
    check("R1 ctl write keeps eep", eep, 0);
    check("R1 ctl write keeps changed", changed, 0);
    bus(0, 0, BASE + 24'd4, 16'h0, 0);
    check("R2 read enabled served", s_win, 1);
    check("R2 read data", s_rdata, 16'h0000);

    bus(1, 0, BASE, 16'h005A, 0);
    check("R7 ram write after ram detect", s_we_e, 1);
    check("R7 eep stays off", eep, 0);
    check("R4 changed after differing write", changed, 1);
    exp_b[0] = 8'h5A;

    for (int i = 0; i < BYTES; i++) begin
      bus(1, 0, BASE + 24'(i), {8'hEE, pat(i, 0)}, 0);
      exp_b[i] = pat(i, 0);
    end
    for (int i = 0; i < BYTES; i++) begin
      bus(0, 0, BASE + 24'(i), 16'h0, 0);
      check("R2 byte readback", {s_win, s_rdata}, {1'b1, 8'h00, exp_b[i]});
    end
    for (int i = 0; i < BYTES; i += 2) begin
      bus(0, 1, BASE + 24'(i) + 24'(i % 4 == 2), 16'h0, 0);
      check("R5 word readback", s_rdata, {exp_b[i], exp_b[i+1]});
    end

    idle_clr();
    check("R9 clear drops flag", changed, 0);
    for (int i = 0; i < BYTES; i++) bus(1, 0, BASE + 24'(i), {8'h11, exp_b[i]}, 0);
    check("R4 identical rewrite keeps flag clear", changed, 0);

    bus(1, 1, BASE + 24'h11, 16'hA1B2, 0);
    exp_b[16] = 8'hA1; exp_b[17] = 8'hB2;
    check("R5 word write both lanes", {s_we_e, s_we_o}, 2'b11);
    check("R4 word write sets flag", changed, 1);
    bus(0, 1, BASE + 24'h10, 16'h0, 0);
    check("R5 word write order", s_rdata, 16'hA1B2);
    bus(0, 0, BASE + 24'h11, 16'h0, 0);
    check("R5 odd byte after word write", s_rdata, 16'h00B2);

    idle_clr();
    bus(1, 0, BASE + 24'h05, {8'h00, ~exp_b[5]}, 1);
    exp_b[5] = ~exp_b[5];
    check("R9 set wins over same-cycle clear", changed, 1);
    bus(0, 0, BASE + 24'h05, 16'h0, 0);
    check("R9 data of collided write", s_rdata, {8'h00, exp_b[5]});

    bus(1, 0, CTL, 16'h0003, 0);
    idle_clr();
    for (int i = 32; i < 40; i++) begin
      bus(1, 0, BASE + 24'(i), {8'h00, ~exp_b[i]}, 0);
      check("R3 protected write no enable", {s_we_e, s_we_o}, 2'b00);
    end
    check("R3 protected writes leave flag", changed, 0);
    for (int i = 32; i < 40; i++) begin
      bus(0, 0, BASE + 24'(i), 16'h0, 0);
      check("R3 protected data kept", s_rdata, {8'h00, exp_b[i]});
    end

    bus(1, 0, CTL, 16'h0002, 0);
    bus(0, 0, BASE + 24'd32, 16'h0, 0);
    check("R2 read enable clear falls to ROM", s_win, 0);
    bus(1, 0, CTL, 16'h00FC, 0);
    bus(0, 1, BASE + 24'd8, 16'h0, 0);
    check("R1 upper data bits ignored", s_win, 0);

    bus(1, 0, CTL, 16'h0001, 0);
    bus(1, 0, 24'h100000, 16'h0077, 0);
    check("R10 outside write no enable", {s_we_e, s_we_o}, 2'b00);
    bus(0, 0, 24'h100000, 16'h0, 0);
    check("R10 outside read not served", s_win, 0);
    bus(0, 1, BASE + 24'(BYTES), 16'h0, 0);
    check("R10 past end not served", s_win, 0);
    bus(0, 0, BASE + 24'(BYTES - 1), 16'h0, 0);
    check("R10 last byte served", {s_win, s_rdata}, {1'b1, 8'h00, exp_b[BYTES-1]});

    // EEPROM detection
    do_reset();
    check("R8 eep cleared by reset", eep, 0);
    bus(1, 0, CTL, 16'h0001, 0);
    bus(1, 0, BASE + 24'd1, 16'h003C, 0);
    check("R6 switching write still reaches RAM", {s_we_e, s_we_o}, 2'b01);
    check("R6 eep on after pair write", eep, 1);
    bus(0, 0, BASE + 24'd4, 16'h0, 0);
    check("R6 window shrunk", s_win, 0);
    bus(1, 0, BASE, 16'h0099, 0);
    check("R6 stub write", {s_eep_we, s_eep_wd}, {1'b1, 8'h99});
    check("R6 no RAM write in eep mode", {s_we_e, s_we_o}, 2'b00);
    eep_rd = 8'h42;
    bus(1, 0, CTL, 16'h0000, 0);
    check("R1 ctl write keeps eep on", eep, 1);
    bus(0, 0, BASE + 24'd1, 16'h0, 0);
    check("R6 stub read ignores read enable", {s_win, s_rdata}, {1'b1, 16'h0042});

    // detection by a plain write elsewhere in the window
    do_reset();
    bus(1, 0, BASE + 24'h10, 16'h0001, 0);
    bus(1, 0, BASE, 16'h0002, 0);
    check("R6 detected by window write, pair write stays RAM", {eep, s_we_e}, 2'b01);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule